// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

This block connects an external master (a host processor or a DMA controller) with an 8-bit data bus to a DSP core that works in 16-bit words. The host sees four byte locations, chosen by two address lines: two byte lanes of a data word and two byte lanes of a status word. Writes to the data location build the inbound word one byte at a time. Reads from the data location take the outbound word apart one byte at a time. The status word can only be read.

The host strobes are active low and asynchronous to the DSP. They are brought into the DSP clock domain before any flag changes. An access takes effect on the synchronized leading edge of the strobe, so the host must hold address and write data stable while its strobe is low.

On the DSP side there are two memory-mapped locations: data and status. The DSP can service the port in three ways:
- by interrupt, using two level outputs that follow the flags;
- by polling the status word;
- by simply accessing the data location, in which case a wait output stalls it until the transfer can complete.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the inbound-full flag is 0, the outbound-empty flag is 1, `dsp_wait` is 0, and the status word reads 0x0002.
- R2: A host write with `hst_addr[1]`=0 puts `hst_din` into the inbound word. `hst_addr[0]`=0 selects bits 7..0 and `hst_addr[0]`=1 selects bits 15..8. A DSP read with `dsp_addr`=0 returns the assembled word.
- R3: The inbound-full flag (`dsp_irq_rx`) sets only when the upper byte (`hst_addr`=01) is written. A write to the lower byte alone leaves it clear.
- R4: A DSP data read while inbound-full is 1 does not wait. The flag is clear from the following cycle.
- R5: A DSP data read while inbound-full is 0 raises `dsp_wait` in the same cycle and leaves the flag at 0.
- R6: Host data writes made while inbound-full is 1 are dropped. The word the DSP then reads is the one that set the flag.
- R7: A host read with `hst_addr`=00 returns outbound bits 7..0, and `hst_addr`=01 returns bits 15..8. Only the upper-byte read sets outbound-empty (`dsp_irq_tx`).
- R8: A DSP write with `dsp_addr`=0 while outbound-empty is 1 loads `dsp_wdata` and clears the flag from the next cycle. While the flag is 0, the write raises `dsp_wait` and the outbound word is kept.
- R9: Status bit 0 is inbound-full and bit 1 is outbound-empty; all other bits are 0. The host reads it at `hst_addr`=10 (bits 7..0) and 11 (bits 15..8). Host writes there change nothing.
- R10: A DSP read with `dsp_addr`=1 returns the 16-bit status word and never waits.
- R11: Strobes take effect only while `hst_cs_n` is low. A flag does not change within two clock edges of the strobe falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSP clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_addr | input | 2 | Bit 1 selects data or status, bit 0 selects the byte lane |
| hst_din | input | 8 | Host write byte |
| hst_dout | output | 8 | Host read byte |
| dsp_addr | input | 1 | 0 selects data, 1 selects status |
| dsp_rd | input | 1 | DSP read request |
| dsp_wr | input | 1 | DSP write request |
| dsp_wdata | input | 16 | DSP write word |
| dsp_rdata | output | 16 | DSP read word |
| dsp_wait | output | 1 | Stall for the current DSP access |
| dsp_irq_rx | output | 1 | Inbound-full flag, usable as an interrupt |
| dsp_irq_tx | output | 1 | Outbound-empty flag, usable as an interrupt |

## Verification
Words are carried in both directions with patterns chosen to tell faults apart:
- all zeros and all ones, which show a stuck lane;
- values whose two bytes differ, which show swapped byte lanes;
- values with a single bit set at either end of the word, which show a bit lost at a lane boundary.

The outbound direction loads each word with its bytes swapped. This separates a bridge that routes the DSP word correctly from one that echoes the inbound word. Directed cases cover the flag timing through the synchronizer, strobes without chip select, and writes while full or not empty. They also cover status writes and stalls in both directions.

// File: rtl/hpb_pkg.sv
`timescale 1ns/1ps
package hpb_pkg;
   typedef enum logic [0:0] {
      SEL_DATA = 1'b0,
      SEL_STAT = 1'b1
   } hpb_sel_e;

   localparam int ST_IN_FULL   = 0;
   localparam int ST_OUT_EMPTY = 1;
endpackage

// File: rtl/hpb_strobe_sync.sv
`timescale 1ns/1ps
module hpb_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic start
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("hpb_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], strobe_n};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign start = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/hpb_in_reg.sv
`timescale 1ns/1ps
module hpb_in_reg #(
   parameter int HOST_W      = 8,
   parameter int LANES       = 2,
   parameter int COMMIT_LANE = 1,
   localparam int LSEL_W     = $clog2(LANES),
   localparam int WORD_W     = HOST_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [LSEL_W-1:0] lane_sel,
   input  logic [HOST_W-1:0] byte_in,
   input  logic              take,
   output logic [WORD_W-1:0] word,
   output logic              full
);
   logic [WORD_W-1:0] word_q;
   logic              full_q;
   logic              accept;

   assign accept = wr_start & ~full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (accept) begin
         for (int i = 0; i < LANES; i++) begin
            if (lane_sel == LSEL_W'(i)) begin
               word_q[i*HOST_W +: HOST_W] <= byte_in;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (take) begin
         full_q <= 1'b0;
      end else if (accept && lane_sel == LSEL_W'(COMMIT_LANE)) begin
         full_q <= 1'b1;
      end
   end

   assign word = word_q;
   assign full = full_q;
endmodule

// File: rtl/hpb_out_reg.sv
`timescale 1ns/1ps
module hpb_out_reg #(
   parameter int HOST_W      = 8,
   parameter int LANES       = 2,
   parameter int COMMIT_LANE = 1,
   localparam int LSEL_W     = $clog2(LANES),
   localparam int WORD_W     = HOST_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rd_start,
   input  logic [LSEL_W-1:0] lane_sel,
   output logic [HOST_W-1:0] byte_out,
   output logic              empty
);
   logic [WORD_W-1:0] word_q;
   logic              empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
      end else if (load) begin
         empty_q <= 1'b0;
      end else if (rd_start && lane_sel == LSEL_W'(COMMIT_LANE)) begin
         empty_q <= 1'b1;
      end
   end

   assign byte_out = word_q[lane_sel*HOST_W +: HOST_W];
   assign empty    = empty_q;
endmodule

// File: rtl/hostport_bridge.sv
`timescale 1ns/1ps
module hostport_bridge
   import hpb_pkg::*;
#(
   parameter int HOST_W      = 8,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int COMMIT_LANE = WORD_W / HOST_W - 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   hst_cs_n,
   input  logic                                   hst_wr_n,
   input  logic                                   hst_rd_n,
   input  logic [$clog2(WORD_W/HOST_W):0]         hst_addr,
   input  logic [HOST_W-1:0]                      hst_din,
   output logic [HOST_W-1:0]                      hst_dout,
   input  logic                                   dsp_addr,
   input  logic                                   dsp_rd,
   input  logic                                   dsp_wr,
   input  logic [WORD_W-1:0]                      dsp_wdata,
   output logic [WORD_W-1:0]                      dsp_rdata,
   output logic                                   dsp_wait,
   output logic                                   dsp_irq_rx,
   output logic                                   dsp_irq_tx
);
   localparam int LANES  = WORD_W / HOST_W;
   localparam int LSEL_W = $clog2(LANES);
   localparam int HA_W   = LSEL_W + 1;

   generate
      if (WORD_W % HOST_W != 0) begin : g_bad_ratio
         $error("hostport_bridge: WORD_W must be a multiple of HOST_W");
      end
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("hostport_bridge: lane count must be a power of two of at least 2");
      end
      if (COMMIT_LANE < 0 || COMMIT_LANE >= LANES) begin : g_bad_commit
         $error("hostport_bridge: COMMIT_LANE out of range");
      end
   endgenerate

   hpb_sel_e          host_sel;
   hpb_sel_e          core_sel;
   logic [LSEL_W-1:0] host_lane;
   logic              wr_start;
   logic              rd_start;
   logic              in_wr_start;
   logic              out_rd_start;
   logic [WORD_W-1:0] in_word;
   logic              in_full;
   logic              out_empty;
   logic [HOST_W-1:0] out_byte;
   logic [WORD_W-1:0] status_w;
   logic              rd_data_req;
   logic              wr_data_req;
   logic              take;
   logic              load;

   assign host_sel  = hpb_sel_e'(hst_addr[HA_W-1]);
   assign host_lane = hst_addr[LSEL_W-1:0];
   assign core_sel  = hpb_sel_e'(dsp_addr);

   hpb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (hst_cs_n | hst_wr_n),
      .start    (wr_start)
   );

   hpb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (hst_cs_n | hst_rd_n),
      .start    (rd_start)
   );

   assign in_wr_start  = wr_start & (host_sel == SEL_DATA);
   assign out_rd_start = rd_start & (host_sel == SEL_DATA);

   assign rd_data_req = dsp_rd & (core_sel == SEL_DATA);
   assign wr_data_req = dsp_wr & (core_sel == SEL_DATA);
   assign take        = rd_data_req & in_full;
   assign load        = wr_data_req & out_empty;
   assign dsp_wait    = (rd_data_req & ~in_full) | (wr_data_req & ~out_empty);

   hpb_in_reg #(
      .HOST_W      (HOST_W),
      .LANES       (LANES),
      .COMMIT_LANE (COMMIT_LANE)
   ) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_start (in_wr_start),
      .lane_sel (host_lane),
      .byte_in  (hst_din),
      .take     (take),
      .word     (in_word),
      .full     (in_full)
   );

   hpb_out_reg #(
      .HOST_W      (HOST_W),
      .LANES       (LANES),
      .COMMIT_LANE (COMMIT_LANE)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .wdata    (dsp_wdata),
      .rd_start (out_rd_start),
      .lane_sel (host_lane),
      .byte_out (out_byte),
      .empty    (out_empty)
   );

   always_comb begin
      status_w               = '0;
      status_w[ST_IN_FULL]   = in_full;
      status_w[ST_OUT_EMPTY] = out_empty;
   end

   assign hst_dout   = (host_sel == SEL_STAT) ? status_w[host_lane*HOST_W +: HOST_W] : out_byte;
   assign dsp_rdata  = (core_sel == SEL_STAT) ? status_w : in_word;
   assign dsp_irq_rx = in_full;
   assign dsp_irq_tx = out_empty;
endmodule

// File: rtl/hpb_checker.sv
`timescale 1ns/1ps
module hpb_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_wr_start,
   input logic              out_rd_start,
   input logic              dsp_addr,
   input logic              dsp_rd,
   input logic              dsp_wr,
   input logic              dsp_wait,
   input logic              dsp_irq_rx,
   input logic              dsp_irq_tx,
   input logic [WORD_W-1:0] in_word
);
   p_full_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsp_irq_rx) |-> $past(in_wr_start));

   p_take_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_rd && !dsp_addr && !dsp_wait) |=> !dsp_irq_rx);

   p_full_word_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_irq_rx && $past(dsp_irq_rx)) |-> $stable(in_word));

   p_empty_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsp_irq_tx) |-> $past(out_rd_start));

   p_load_clears_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_wr && !dsp_addr && !dsp_wait) |=> !dsp_irq_tx);

   p_status_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_addr && (dsp_rd || dsp_wr)) |-> !dsp_wait);
endmodule

bind hostport_bridge hpb_checker #(.WORD_W(WORD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_wr_start  (in_wr_start),
   .out_rd_start (out_rd_start),
   .dsp_addr     (dsp_addr),
   .dsp_rd       (dsp_rd),
   .dsp_wr       (dsp_wr),
   .dsp_wait     (dsp_wait),
   .dsp_irq_rx   (dsp_irq_rx),
   .dsp_irq_tx   (dsp_irq_tx),
   .in_word      (in_word)
);

// File: tb/hostport_bridge_bench.sv
`timescale 1ns/1ps
module hostport_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_cs_n = 1'b1;
   logic        hst_wr_n = 1'b1;
   logic        hst_rd_n = 1'b1;
   logic [1:0]  hst_addr = 2'b00;
   logic [7:0]  hst_din = 8'h00;
   logic [7:0]  hst_dout;
   logic        dsp_addr = 1'b0;
   logic        dsp_rd = 1'b0;
   logic        dsp_wr = 1'b0;
   logic [15:0] dsp_wdata = 16'h0000;
   logic [15:0] dsp_rdata;
   logic        dsp_wait;
   logic        dsp_irq_rx;
   logic        dsp_irq_tx;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   hostport_bridge u_hostport_bridge (
      .clk        (clk),
      .rst_n      (rst_n),
      .hst_cs_n   (hst_cs_n),
      .hst_wr_n   (hst_wr_n),
      .hst_rd_n   (hst_rd_n),
      .hst_addr   (hst_addr),
      .hst_din    (hst_din),
      .hst_dout   (hst_dout),
      .dsp_addr   (dsp_addr),
      .dsp_rd     (dsp_rd),
      .dsp_wr     (dsp_wr),
      .dsp_wdata  (dsp_wdata),
      .dsp_rdata  (dsp_rdata),
      .dsp_wait   (dsp_wait),
      .dsp_irq_rx (dsp_irq_rx),
      .dsp_irq_tx (dsp_irq_tx)
   );

   localparam logic [15:0] VEC [8] = '{
      16'h0000, 16'hFFFF, 16'hA55A, 16'h00FF,
      16'hFF00, 16'h1234, 16'h8001, 16'h7FFE
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
      @(negedge clk);
      hst_addr = a; hst_din = d; hst_cs_n = ~sel; hst_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      hst_wr_n = 1'b1; hst_cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic host_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      hst_addr = a; hst_cs_n = 1'b0; hst_rd_n = 1'b0;
      #1 d = hst_dout;
      repeat (4) @(negedge clk);
      hst_rd_n = 1'b1; hst_cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic dsp_read(input logic a, output logic [15:0] d, output logic w);
      @(negedge clk);
      dsp_addr = a; dsp_rd = 1'b1;
      #1 d = dsp_rdata; w = dsp_wait;
      @(negedge clk);
      dsp_rd = 1'b0;
      #1;
   endtask

   task automatic dsp_write(input logic [15:0] d, output logic w);
      @(negedge clk);
      dsp_addr = 1'b0; dsp_wdata = d; dsp_wr = 1'b1;
      #1 w = dsp_wait;
      @(negedge clk);
      dsp_wr = 1'b0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] w16;
      logic [7:0]  b;
      logic        wt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 irq_rx", 16'(dsp_irq_rx), 16'h0);
      chk("R1 irq_tx", 16'(dsp_irq_tx), 16'h1);
      chk("R1 wait",   16'(dsp_wait),   16'h0);
      host_read(2'b10, b);
      chk("R1 status low", 16'(b), 16'h0002);

      // table walk: R2 R3 R4 R7 R8
      for (int i = 0; i < 8; i++) begin
         host_write(2'b00, VEC[i][7:0], 1'b1);
         chk("R3 low byte only", 16'(dsp_irq_rx), 16'h0);
         host_write(2'b01, VEC[i][15:8], 1'b1);
         chk("R3 upper byte sets full", 16'(dsp_irq_rx), 16'h1);
         dsp_read(1'b0, w16, wt);
         chk("R2 word", w16, VEC[i]);
         chk("R4 no wait", 16'(wt), 16'h0);
         chk("R4 full cleared", 16'(dsp_irq_rx), 16'h0);
         dsp_write({VEC[i][7:0], VEC[i][15:8]}, wt);
         chk("R8 accepted", 16'(wt), 16'h0);
         chk("R8 empty cleared", 16'(dsp_irq_tx), 16'h0);
         host_read(2'b00, b);
         chk("R7 low byte", 16'(b), 16'(VEC[i][15:8]));
         chk("R7 low read keeps not-empty", 16'(dsp_irq_tx), 16'h0);
         host_read(2'b01, b);
         chk("R7 high byte", 16'(b), 16'(VEC[i][7:0]));
         chk("R7 empty set", 16'(dsp_irq_tx), 16'h1);
      end

      // R9: status is read-only from the host
      host_write(2'b10, 8'hFF, 1'b1);
      host_write(2'b11, 8'hFF, 1'b1);
      chk("R9 status write no full", 16'(dsp_irq_rx), 16'h0);
      host_read(2'b10, b);
      chk("R9 status low", 16'(b), 16'h0002);
      host_read(2'b11, b);
      chk("R9 status high", 16'(b), 16'h0000);

      // R10: DSP status read
      dsp_read(1'b1, w16, wt);
      chk("R10 status word", w16, 16'h0002);
      chk("R10 no wait", 16'(wt), 16'h0);

      // R11: no chip select means no effect
      host_write(2'b01, 8'h77, 1'b0);
      chk("R11 no cs ignored", 16'(dsp_irq_rx), 16'h0);

      // R11: synchronizer latency
      host_write(2'b00, 8'h5A, 1'b1);
      @(negedge clk);
      hst_addr = 2'b01; hst_din = 8'hC3; hst_cs_n = 1'b0; hst_wr_n = 1'b0;
      @(negedge clk);
      chk("R11 latency edge1", 16'(dsp_irq_rx), 16'h0);
      @(negedge clk);
      chk("R11 latency edge2", 16'(dsp_irq_rx), 16'h0);
      repeat (3) @(negedge clk);
      hst_wr_n = 1'b1; hst_cs_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 commit after sync", 16'(dsp_irq_rx), 16'h1);

      // R10 with full status
      dsp_read(1'b1, w16, wt);
      chk("R10 status full", w16, 16'h0003);

      // R6: writes while full dropped
      host_write(2'b00, 8'h11, 1'b1);
      host_write(2'b01, 8'h22, 1'b1);
      dsp_read(1'b0, w16, wt);
      chk("R6 original word kept", w16, 16'hC35A);
      chk("R6 irq_rx cleared", 16'(dsp_irq_rx), 16'h0);

      // R5: read while empty waits
      dsp_read(1'b0, w16, wt);
      chk("R5 wait asserted", 16'(wt), 16'h1);
      chk("R5 flag unchanged", 16'(dsp_irq_rx), 16'h0);

      // R8: write while not empty waits and keeps the word
      dsp_write(16'hBEEF, wt);
      chk("R8 first accepted", 16'(wt), 16'h0);
      dsp_write(16'h1234, wt);
      chk("R8 second waits", 16'(wt), 16'h1);
      host_read(2'b00, b);
      chk("R8 kept low", 16'(b), 16'h00EF);
      host_read(2'b01, b);
      chk("R8 kept high", 16'(b), 16'h00BE);
      chk("R7 empty after drain", 16'(dsp_irq_tx), 16'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule